// File: doc/BRIEF.md
# Serialized Key-Mixing FL Transform

This block applies the 32-bit key-dependent FL mixing layer of a Feistel block cipher, spread over several clock cycles so that one narrow AND/OR/XOR slice does the work that a full-width implementation spreads across 16 lanes. The word is treated as a high half `L` (bits 31:16) and a low half `R` (bits 15:0). Two 16-bit subkeys control the mixing. First, `R` is XORed with `L AND key_a`. Then `L` is XORed with `new R OR key_b`.

Both steps are bitwise, so bit position i of the second step depends only on bit position i of the first step. Each cycle therefore handles one bit slice of both steps together. In the fast mode a cycle covers 8 bit positions and the transform finishes in 2 cycles. In the slim mode a cycle covers 4 bit positions and the transform finishes in 4 cycles. The working registers rotate by one slice each cycle, so after the last slice every bit is back in its original position and the registers hold the finished word.

A controller loads the word on an accepted start, taking it from one of two sources: the plaintext input or the round-function output. It then raises a one-cycle completion pulse. The subkeys must stay stable while the block is busy.

Top module: `fl_serial`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: When `done` is high, `result` = {L ^ (R' | key_b), R'} with R' = R ^ (L & key_a), where L is bits 31:16 and R is bits 15:0 of the loaded word.
- R3: An accepted start loads `pt_word` when `src_round` is 0 and `rf_word` when `src_round` is 1.
- R4: A start seen while `busy` is 0 is accepted. `done` then rises exactly 2 clock edges after the accepting edge when `slim` was 0 at that edge, and exactly 4 edges after it when `slim` was 1.
- R5: `done` is high for exactly one cycle per accepted start and is never high together with `busy`.
- R6: Once `done` has pulsed, `result` holds its value and `done` stays low until the next accepted start.
- R7: A start asserted while `busy` is 1 is ignored. The data words presented with it do not reach `result`, and the running transform's latency is unchanged.
- R8: The mode is sampled only on the accepting edge. Toggling `slim` while busy changes neither latency nor result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; taken only when idle |
| src_round | input | 1 | Source select: 0 plaintext, 1 round-function output |
| slim | input | 1 | Mode: 0 = 8-bit slices (2 cycles), 1 = 4-bit slices (4 cycles) |
| pt_word | input | 32 | Plaintext-side input word |
| rf_word | input | 32 | Round-function-side input word |
| key_a | input | 16 | Subkey ANDed in the first step |
| key_b | input | 16 | Subkey ORed in the second step |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Transformed word, registered |

## Verification
The bench builds the block with its default sizes: 16-bit halves, 2 steps in the fast mode and 4 in the slim mode. With these sizes both slice widths run, along with the rotation that walks every subkey slice past the shared logic. Random words and subkeys are run in both modes and from both sources. Directed cases cover all-ones and all-zero keys, start pulses and mode flips injected mid-run, and idle cycles after completion in which the inputs change but the result must not.

// File: rtl/fl_ser_pkg.sv
package fl_ser_pkg;
  typedef enum logic {SRC_PLAIN = 1'b0, SRC_ROUND = 1'b1} src_sel_e;

  function automatic int unsigned idx_bits(input int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction
endpackage

// File: rtl/fl_slice.sv
module fl_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] l_in,
  input  logic [W-1:0] r_in,
  input  logic [W-1:0] ka,
  input  logic [W-1:0] kb,
  output logic [W-1:0] l_out,
  output logic [W-1:0] r_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic r_new;
    assign r_new    = r_in[b] ^ (l_in[b] & ka[b]);
    assign r_out[b] = r_new;
    assign l_out[b] = l_in[b] ^ (r_new | kb[b]);
  end
endmodule

// File: rtl/fl_seq.sv
module fl_seq #(
  parameter int WIDE_STEPS   = 2,
  parameter int NARROW_STEPS = 4,
  parameter int CW           = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          slim_in,
  output logic          busy,
  output logic          done,
  output logic          load,
  output logic          slim_q,
  output logic [CW-1:0] idx
);
  logic last;

  assign load = start && !busy;
  assign last = slim_q ? (idx == CW'(NARROW_STEPS - 1)) : (idx == CW'(WIDE_STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      slim_q <= 1'b0;
      idx    <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        slim_q <= slim_in;
        idx    <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) !(done && busy)); // R5
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(busy)); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst) (busy && !load) |=> (!busy || $stable(slim_q))); // R8
endmodule

// File: rtl/fl_datapath.sv
module fl_datapath #(
  parameter int HALF_W   = 16,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4,
  parameter int CW       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                adv,
  input  logic                slim,
  input  logic [CW-1:0]       idx,
  input  logic [2*HALF_W-1:0] din,
  input  logic [HALF_W-1:0]   ka,
  input  logic [HALF_W-1:0]   kb,
  output logic [2*HALF_W-1:0] dout
);
  localparam int OW = $clog2(HALF_W) + 1;

  logic [HALF_W-1:0] lq, rq;
  logic [OW-1:0]     step_w, offs;
  logic [HALF_W-1:0] ka_sh, kb_sh;
  logic [WIDE_W-1:0] l_new, r_new;

  assign step_w = slim ? OW'(NARROW_W) : OW'(WIDE_W);
  assign offs   = OW'(idx) * step_w;
  assign ka_sh  = ka >> offs;
  assign kb_sh  = kb >> offs;

  fl_slice #(.W(WIDE_W)) u_slice (
    .l_in (lq[WIDE_W-1:0]),
    .r_in (rq[WIDE_W-1:0]),
    .ka   (ka_sh[WIDE_W-1:0]),
    .kb   (kb_sh[WIDE_W-1:0]),
    .l_out(l_new),
    .r_out(r_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lq <= '0;
      rq <= '0;
    end else if (load) begin
      lq <= din[2*HALF_W-1:HALF_W];
      rq <= din[HALF_W-1:0];
    end else if (adv) begin
      if (slim) begin
        lq <= {l_new[NARROW_W-1:0], lq[HALF_W-1:NARROW_W]};
        rq <= {r_new[NARROW_W-1:0], rq[HALF_W-1:NARROW_W]};
      end else begin
        lq <= {l_new, lq[HALF_W-1:WIDE_W]};
        rq <= {r_new, rq[HALF_W-1:WIDE_W]};
      end
    end
  end

  assign dout = {lq, rq};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!load && !adv) |=> $stable(dout)); // R6
endmodule

// File: rtl/fl_serial.sv
module fl_serial #(
  parameter int HALF_W       = 16,
  parameter int WIDE_STEPS   = 2,
  parameter int NARROW_STEPS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                src_round,
  input  logic                slim,
  input  logic [2*HALF_W-1:0] pt_word,
  input  logic [2*HALF_W-1:0] rf_word,
  input  logic [HALF_W-1:0]   key_a,
  input  logic [HALF_W-1:0]   key_b,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] result
);
  import fl_ser_pkg::*;

  localparam int WIDE_W   = HALF_W / WIDE_STEPS;
  localparam int NARROW_W = HALF_W / NARROW_STEPS;
  localparam int CW       = idx_bits(NARROW_STEPS);

  logic          load, slim_q;
  logic [CW-1:0] idx;
  logic [2*HALF_W-1:0] din;
  src_sel_e      src;

  assign src = src_sel_e'(src_round);
  assign din = (src == SRC_ROUND) ? rf_word : pt_word;

  fl_seq #(
    .WIDE_STEPS  (WIDE_STEPS),
    .NARROW_STEPS(NARROW_STEPS),
    .CW          (CW)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .slim_in(slim),
    .busy   (busy),
    .done   (done),
    .load   (load),
    .slim_q (slim_q),
    .idx    (idx)
  );

  fl_datapath #(
    .HALF_W  (HALF_W),
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W),
    .CW      (CW)
  ) u_dp (
    .clk (clk),
    .rst (rst),
    .load(load),
    .adv (busy),
    .slim(slim_q),
    .idx (idx),
    .din (din),
    .ka  (key_a),
    .kb  (key_b),
    .dout(result)
  );

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (start && busy && !done) |=> (busy || done)); // R7
endmodule

// File: tb/fl_serial_bench.sv
module fl_serial_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        src_round = 1'b0;
  logic        slim = 1'b0;
  logic [31:0] pt_word = '0;
  logic [31:0] rf_word = '0;
  logic [15:0] key_a = '0;
  logic [15:0] key_b = '0;
  logic        busy, done;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fl_serial u_fl_serial (
    .clk(clk), .rst(rst), .start(start), .src_round(src_round), .slim(slim),
    .pt_word(pt_word), .rf_word(rf_word), .key_a(key_a), .key_b(key_b),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] fl_ref(input logic [31:0] d, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] l, r;
    l = d[31:16];
    r = d[15:0];
    r = r ^ (l & a);
    l = l ^ (r | b);
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transform; optional mid-run start pulse (R7) and mode flip (R8)
  task automatic run_op(input logic [31:0] pt, input logic [31:0] rf, input logic [15:0] ka,
                        input logic [15:0] kb, input bit sel, input bit nar,
                        input bit poke_start, input bit poke_mode);
    int n;
    logic [31:0] exp;
    logic [31:0] held;
    exp = fl_ref(sel ? rf : pt, ka, kb);
    @(negedge clk);
    pt_word = pt; rf_word = rf; key_a = ka; key_b = kb;
    src_round = sel; slim = nar; start = 1'b1;
    @(negedge clk);
    n = 1;
    start = 1'b0;
    if (poke_start) begin
      start = 1'b1;
      pt_word = ~pt;
      rf_word = ~rf;
      src_round = ~sel;
    end
    if (poke_mode) slim = ~nar;
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
      start = 1'b0;
    end
    // R4 latency (R7, R8 keep it unchanged)
    chk(n == (nar ? 5 : 3), "R4/R7/R8 latency", 32'(n), nar ? 32'd5 : 32'd3);
    // R2 / R3 result
    chk(result == exp, "R2/R3 result", result, exp);
    held = result;
    pt_word = $urandom;
    rf_word = $urandom;
    @(negedge clk);
    chk(!done && !busy, "R5 single done pulse", {30'd0, busy, done}, 32'd0);
    @(negedge clk);
    chk(result == held && !done, "R6 result held", result, held);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy && !done && result == 32'd0, "R1 reset", result, 32'd0);

    // directed corners
    run_op(32'hFFFF_FFFF, 32'h0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op(32'h1234_5678, 32'h0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(32'h0, 32'hA5A5_3C3C, 16'hF0F0, 16'h0F0F, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(32'hDEAD_BEEF, 32'h0BAD_F00D, 16'h8001, 16'h7FFE, 1'b0, 1'b0, 1'b1, 1'b0); // R7
    run_op(32'hCAFE_0001, 32'h1357_9BDF, 16'h3C5A, 16'hA53C, 1'b1, 1'b1, 1'b1, 1'b0); // R7
    run_op(32'h0F0F_F0F0, 32'h0, 16'h1111, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b1); // R8
    run_op(32'h0, 32'h8888_7777, 16'hABCD, 16'h4321, 1'b1, 1'b1, 1'b0, 1'b1); // R8

    // constrained random, both modes, both sources
    for (int i = 0; i < 40; i++) begin
      run_op($urandom, $urandom, 16'($urandom), 16'($urandom),
             1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule